// File: doc/BRIEF.md
# Debug-Aware Power and Reset Sequencer

This block controls power and reset for one processor core domain and the trace domain beside it. When the core is idle it may ask for one of two things. It can ask for standby, where clocks are gated but state is kept. It can ask for a full power-down, which is acknowledged, held until a wake event, and then followed by a power-up and a reset pulse.

A debugger-driven input selects emulate mode. In emulate mode the sequencer walks through exactly the same states and handshake as a real power-down, but with three differences:

- both power enables stay high;
- both core interrupt lines are masked during the emulated off period, so an interrupt cannot end the core's wait;
- power-up uses the warm core reset instead of the power-on reset, so debug registers survive.

In standby, a halting debug request wakes the core when the clock-keep-alive input is high. The current state is visible on a status output.

Top module: `dbg_pwr_seq`

## Requirements
- R1: The emulate-mode input is sampled on the cycle a power-down request is accepted in RUN. Changes to it before the sequence returns to RUN have no effect on power, mask or reset outputs.
- R2: In emulate mode, `core_pwr_en_o` and `trace_pwr_en_o` stay high through the whole power-down and power-up sequence.
- R3: In normal mode, both power enables are low exactly while the state is OFF_OR_EMULATED (code 3). They are high in every other state.
- R4: Sequence and `state_o` codes are identical in both modes. RUN (0) with `pd_req_i` goes to PWR_DOWN_REQ (2) for one cycle. It then goes to OFF_OR_EMULATED (3), where `pd_ack_o` is high, until `wake_i`. It then goes to PWR_UP (4) for SETTLE_CYC cycles, then to RESET_RELEASE (5) for RST_CYC cycles, then back to RUN.
- R5: In emulate mode, `irq_mask_o` is 2'b11 in states 3, 4 and 5. It drops to 2'b00 on return to RUN, after the warm reset has fallen. In normal mode it is always 2'b00.
- R6: On power-up after an emulated power-down, `warm_rst_o` is high for the RST_CYC cycles of RESET_RELEASE and `por_o` stays low.
- R7: On power-up after a real power-down, `por_o` is high for the RST_CYC cycles of RESET_RELEASE and `warm_rst_o` stays low.
- R8: While `rst_ni` is low, and for RST_CYC cycles after it rises, the state is RESET_RELEASE with `por_o` high. After that the state is RUN.
- R9: `sby_req_i` in RUN moves to STANDBY (1) with both power enables high and no reset or mask asserted. `wake_i` in STANDBY returns to RUN.
- R10: In STANDBY, `halt_req_i` returns to RUN on the next cycle when `keep_clk_i` is high. It is ignored when `keep_clk_i` is low.
- R11: In RUN, `pd_req_i` takes priority over `sby_req_i`, and `wake_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_req_i | input | 1 | Power-down request from idle core |
| sby_req_i | input | 1 | Standby request from idle core |
| wake_i | input | 1 | Wake event |
| halt_req_i | input | 1 | Halting debug request |
| keep_clk_i | input | 1 | Debugger clock-keep-alive |
| emu_en_i | input | 1 | Emulate-mode select from debugger |
| core_pwr_en_o | output | 1 | Core domain power enable |
| trace_pwr_en_o | output | 1 | Trace domain power enable |
| irq_mask_o | output | 2 | Mask for the two core interrupt lines |
| por_o | output | 1 | Power-on reset, active high |
| warm_rst_o | output | 1 | Warm core reset, active high |
| pd_ack_o | output | 1 | Power-down acknowledge |
| state_o | output | 3 | Current state code |

## Verification
The assertions check the following on every cycle:

- power is never removed while emulating;
- the two resets are never high together;
- power falls only after the request state;
- the latched mode stays stable during a sequence;
- the interrupt mask falls only in RUN, once the warm reset is already low;
- OFF and the request state move only to their legal successors.

The bench's scenarios show the rest: the exact cycle counts of the settle and reset windows, the effect of toggling the mode input mid-sequence, varied wake delays, request priority, and the keep-alive gating of halt wake-up.

// File: rtl/dbg_pwr_pkg.sv
package dbg_pwr_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_STANDBY = 3'd1,
    ST_PD_REQ  = 3'd2,
    ST_OFF     = 3'd3,
    ST_PWR_UP  = 3'd4,
    ST_RST_REL = 3'd5
  } pwr_st_e;
endpackage

// File: rtl/dbg_pwr_timer.sv
module dbg_pwr_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (clr_i)             cnt_o <= '0;
    else if (cnt_o != {CW{1'b1}}) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dbg_pwr_fsm.sv
module dbg_pwr_fsm
  import dbg_pwr_pkg::*;
#(
  parameter int SETTLE_CYC = 8,
  parameter int RST_CYC    = 16
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    pd_req_i,
  input  logic    sby_req_i,
  input  logic    wake_i,
  input  logic    halt_req_i,
  input  logic    keep_clk_i,
  input  logic    emu_en_i,
  output pwr_st_e st_o,
  output logic    emu_o
);
  localparam int MAXC = (SETTLE_CYC > RST_CYC) ? SETTLE_CYC : RST_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] RST_LAST    = CW'(RST_CYC - 1);

  pwr_st_e st_q, st_d;
  logic    emu_q;
  logic [CW-1:0] cnt;

  dbg_pwr_timer #(.CW(CW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st_d != st_q),
    .cnt_o (cnt)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:     if (pd_req_i) st_d = ST_PD_REQ;
                  else if (sby_req_i) st_d = ST_STANDBY;
      ST_STANDBY: if (wake_i || (halt_req_i && keep_clk_i)) st_d = ST_RUN;
      ST_PD_REQ:  st_d = ST_OFF;
      ST_OFF:     if (wake_i) st_d = ST_PWR_UP;
      ST_PWR_UP:  if (cnt == SETTLE_LAST) st_d = ST_RST_REL;
      ST_RST_REL: if (cnt == RST_LAST) st_d = ST_RUN;
      default:    st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RST_REL;
      emu_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_RUN && pd_req_i) emu_q <= emu_en_i;
    end
  end

  assign st_o  = st_q;
  assign emu_o = emu_q;

  // mode latched for whole sequence
  assert_emu_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_RUN) |=> $stable(emu_q));
  assert_req_to_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PD_REQ) |=> (st_q == ST_OFF));
  assert_off_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OFF) |=> (st_q == ST_OFF || st_q == ST_PWR_UP));
  assert_halt_wake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_STANDBY && halt_req_i && keep_clk_i) |=> (st_q == ST_RUN));
endmodule

// File: rtl/dbg_pwr_decode.sv
module dbg_pwr_decode
  import dbg_pwr_pkg::*;
#(
  parameter int NIRQ = 2
) (
  input  pwr_st_e         st_i,
  input  logic            emu_i,
  output logic            core_pwr_o,
  output logic            trace_pwr_o,
  output logic [NIRQ-1:0] irq_mask_o,
  output logic            por_o,
  output logic            warm_o,
  output logic            ack_o
);
  logic off_real, emu_window;

  always_comb begin
    off_real   = (st_i == ST_OFF) && !emu_i;
    emu_window = emu_i && (st_i == ST_OFF || st_i == ST_PWR_UP || st_i == ST_RST_REL);
    core_pwr_o  = !off_real;
    trace_pwr_o = !off_real;
    irq_mask_o  = {NIRQ{emu_window}};
    por_o  = (st_i == ST_RST_REL) && !emu_i;
    warm_o = (st_i == ST_RST_REL) && emu_i;
    ack_o  = (st_i == ST_OFF);
  end
endmodule

// File: rtl/dbg_pwr_seq.sv
module dbg_pwr_seq
  import dbg_pwr_pkg::*;
#(
  parameter int SETTLE_CYC = 8,
  parameter int RST_CYC    = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pd_req_i,
  input  logic       sby_req_i,
  input  logic       wake_i,
  input  logic       halt_req_i,
  input  logic       keep_clk_i,
  input  logic       emu_en_i,
  output logic       core_pwr_en_o,
  output logic       trace_pwr_en_o,
  output logic [1:0] irq_mask_o,
  output logic       por_o,
  output logic       warm_rst_o,
  output logic       pd_ack_o,
  output logic [2:0] state_o
);
  pwr_st_e st;
  logic    emu;

  dbg_pwr_fsm #(.SETTLE_CYC(SETTLE_CYC), .RST_CYC(RST_CYC)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pd_req_i  (pd_req_i),
    .sby_req_i (sby_req_i),
    .wake_i    (wake_i),
    .halt_req_i(halt_req_i),
    .keep_clk_i(keep_clk_i),
    .emu_en_i  (emu_en_i),
    .st_o      (st),
    .emu_o     (emu)
  );

  dbg_pwr_decode #(.NIRQ(2)) u_dec (
    .st_i       (st),
    .emu_i      (emu),
    .core_pwr_o (core_pwr_en_o),
    .trace_pwr_o(trace_pwr_en_o),
    .irq_mask_o (irq_mask_o),
    .por_o      (por_o),
    .warm_o     (warm_rst_o),
    .ack_o      (pd_ack_o)
  );

  assign state_o = st;

  assert_emu_powered_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emu && st != ST_RUN && st != ST_STANDBY) |-> (core_pwr_en_o && trace_pwr_en_o));
  assert_pwr_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_pwr_en_o) |-> ($past(st) == ST_PD_REQ));
  assert_mask_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_mask_o[0]) |-> (st == ST_RUN && !warm_rst_o));
  assert_one_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(por_o && warm_rst_o));
endmodule

// File: tb/dbg_pwr_seq_bench.sv
module dbg_pwr_seq_bench;
  localparam int SETTLE = 3;
  localparam int RSTC   = 4;

  logic clk = 0, rst_n = 0;
  logic pd_req = 0, sby_req = 0, wake = 0, halt = 0, keep = 0, emu_en = 0;
  logic core_pwr, trace_pwr, por, warm, ack;
  logic [1:0] mask;
  logic [2:0] st;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_pwr_seq #(.SETTLE_CYC(SETTLE), .RST_CYC(RSTC)) u_dbg_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .pd_req_i(pd_req), .sby_req_i(sby_req),
    .wake_i(wake), .halt_req_i(halt), .keep_clk_i(keep), .emu_en_i(emu_en),
    .core_pwr_en_o(core_pwr), .trace_pwr_en_o(trace_pwr), .irq_mask_o(mask),
    .por_o(por), .warm_rst_o(warm), .pd_ack_o(ack), .state_o(st)
  );

  // packed view: {state, core, trace, mask, por, warm, ack}
  task automatic chk(string req, logic [2:0] es, logic ep, logic [1:0] em,
                     logic epor, logic ewarm, logic eack);
    logic [9:0] act, exp;
    act = {st, core_pwr, trace_pwr, mask, por, warm, ack};
    exp = {es, ep, ep, em, epor, ewarm, eack};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic power_cycle(bit emu, bit flip, int wdelay);
    emu_en = emu; pd_req = 1;
    step();
    pd_req = 0;
    if (flip) emu_en = !emu;
    chk("R4 req", 3'd2, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    step();
    for (int i = 0; i <= wdelay; i++) begin
      chk(emu ? "R2 R5 off" : "R3 off", 3'd3, emu, {2{emu}}, 1'b0, 1'b0, 1'b1);
      if (i == wdelay) wake = 1;
      step();
    end
    wake = 0;
    for (int i = 0; i < SETTLE; i++) begin
      chk("R4 R1 settle", 3'd4, 1'b1, {2{emu}}, 1'b0, 1'b0, 1'b0);
      step();
    end
    for (int i = 0; i < RSTC; i++) begin
      chk(emu ? "R6 R1 warm" : "R7 R1 por", 3'd5, 1'b1, {2{emu}}, !emu, emu, 1'b0);
      step();
    end
    chk("R5 run", 3'd0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    emu_en = 0;
  endtask

  initial begin
    repeat (3) step();
    chk("R8 in reset", 3'd5, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0);
    rst_n = 1;
    for (int i = 0; i < RSTC; i++) begin
      chk("R8 por", 3'd5, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0);
      step();
    end
    chk("R8 run", 3'd0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);

    for (int e = 0; e < 2; e++)
      for (int f = 0; f < 2; f++)
        for (int d = 0; d < 3; d++)
          power_cycle(bit'(e), bit'(f), d);

    // R11: wake in RUN ignored, pd over sby
    wake = 1; step(); wake = 0;
    chk("R11 wake ignored", 3'd0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    pd_req = 1; sby_req = 1; step(); pd_req = 0; sby_req = 0;
    chk("R11 priority", 3'd2, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    step(); wake = 1; step(); wake = 0;
    repeat (SETTLE + RSTC) step();
    chk("R11 back", 3'd0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);

    // R9, R10 standby
    sby_req = 1; step(); sby_req = 0;
    chk("R9 standby", 3'd1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    halt = 1; keep = 0;
    repeat (3) begin
      step();
      chk("R10 halt no keep", 3'd1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    end
    keep = 1; step(); halt = 0; keep = 0;
    chk("R10 halt wake", 3'd0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    sby_req = 1; step(); sby_req = 0;
    chk("R9 standby again", 3'd1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    wake = 1; step(); wake = 0;
    chk("R9 wake", 3'd0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule